// File: doc/BRIEF.md
# Last-Value Load Predictor with Miss Tracking

This block predicts the value a load instruction will return, based on the last value that load committed. It keeps a direct-mapped table indexed by the low bits of the load's word address and tagged by the remaining bits. A fetch-time lookup returns, one cycle later, a hit flag, the stored value and a flag saying whether confidence is high enough to act on the value. When the load retires, the commit port supplies the actual value and whether the earlier prediction was right. The entry then takes the new value and updates its confidence and miss counters.

Each entry also carries an up/down miss counter. When a load mispredicts often enough that this counter climbs past a threshold, the block emits a one-cycle promotion event carrying that load's word address. A separate pattern buffer can then take over that load. The counter restarts from zero after each event. All addresses on the ports are word addresses, with the byte-offset bits already removed.

Top module: `last_value_predictor`

## Requirements
- R1: After reset no entry is valid: a lookup returns hit 0, use 0, value 0, and no promotion event occurs.
- R2: A lookup presented in cycle n yields pred_valid_o in cycle n+1. pred_hit_o is 1 only if the entry at index lookup_addr_i[IDX_W-1:0] is valid and its stored tag equals lookup_addr_i[WADDR_W-1:IDX_W].
- R3: On a hit, pred_value_o equals the value of the most recent commit to that address. On a miss, pred_value_o is 0.
- R4: A commit whose address misses the table allocates the entry at its index, replacing any previous tag there. The new entry holds the committed value, confidence 0 and miss count 0, and the commit_correct_i input is ignored for it.
- R5: Confidence is a 2-bit counter. A commit that hits the table with commit_correct_i=1 increments it, saturating at 3. A commit that hits with commit_correct_i=0 clears it to 0.
- R6: pred_use_o is 1 only on a hit whose confidence is 2 or 3.
- R7: The 4-bit miss counter increments on a hitting commit with commit_correct_i=0 and decrements on one with commit_correct_i=1. It saturates at 0 and at 15.
- R8: When a mispredicting commit would raise the miss counter above MISS_THRESH (default 8, so the ninth net miss), promo_valid_o is 1 for one cycle, in the cycle after that commit. promo_addr_o then equals the commit's word address, and the counter is cleared to 0.
- R9: A lookup and a commit to the same entry in the same cycle: the lookup returns the entry's contents from before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Fetch-time lookup request |
| lookup_addr_i | input | WADDR_W | Word address of the fetched load |
| pred_valid_o | output | 1 | Lookup result valid |
| pred_hit_o | output | 1 | Tag matched a valid entry |
| pred_use_o | output | 1 | Confidence high enough to use the prediction |
| pred_value_o | output | DATA_W | Predicted value |
| commit_valid_i | input | 1 | Load commit |
| commit_addr_i | input | WADDR_W | Word address of the committing load |
| commit_value_i | input | DATA_W | Actual loaded value |
| commit_correct_i | input | 1 | The earlier prediction for this load was correct |
| promo_valid_o | output | 1 | One-cycle promotion event |
| promo_addr_o | output | WADDR_W | Word address of the promoted load |

## Verification
Assertions check the following on every cycle: the one-cycle lookup latency, that use implies hit and hit implies a valid result, and that every promotion follows a mispredicting commit and carries its address. Only directed scenarios can show the counter arithmetic. These include the clearing of confidence, as opposed to decrementing it, the saturation of the miss counter at zero, the exact ninth-miss promotion point, and the restart after a promotion. The same holds for allocation replacing an aliasing tag and for a lookup in the same cycle as a commit seeing the old contents.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_ALLOC   = 2'd1,
    UPD_HIT_OK  = 2'd2,
    UPD_HIT_BAD = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/lvp_table.sv
module lvp_table #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32,
  parameter int CONF_W = 2,
  parameter int MISS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic              lk_valid_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [DATA_W-1:0] lk_data_o,
  output logic [CONF_W-1:0] lk_conf_o,
  input  logic [IDX_W-1:0]  cm_idx_i,
  output logic              cm_valid_o,
  output logic [TAG_W-1:0]  cm_tag_o,
  output logic [CONF_W-1:0] cm_conf_o,
  output logic [MISS_W-1:0] cm_miss_o,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CONF_W-1:0] wr_conf_i,
  input  logic [MISS_W-1:0] wr_miss_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic              valid_q [DEPTH];
  logic [TAG_W-1:0]  tag_q   [DEPTH];
  logic [DATA_W-1:0] data_q  [DEPTH];
  logic [CONF_W-1:0] conf_q  [DEPTH];
  logic [MISS_W-1:0] miss_q  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (cm_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        conf_q[e]  <= '0;
        miss_q[e]  <= '0;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
        conf_q[e]  <= wr_conf_i;
        miss_q[e]  <= wr_miss_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[e]  <= wr_tag_i;
        data_q[e] <= wr_data_i;
      end
    end
  end

  assign lk_valid_o = valid_q[lk_idx_i];
  assign lk_tag_o   = tag_q[lk_idx_i];
  assign lk_data_o  = data_q[lk_idx_i];
  assign lk_conf_o  = conf_q[lk_idx_i];

  assign cm_valid_o = valid_q[cm_idx_i];
  assign cm_tag_o   = tag_q[cm_idx_i];
  assign cm_conf_o  = conf_q[cm_idx_i];
  assign cm_miss_o  = miss_q[cm_idx_i];
endmodule

// File: rtl/lvp_update.sv
module lvp_update
  import lvp_pkg::*;
#(
  parameter int CONF_W      = 2,
  parameter int MISS_W      = 4,
  parameter int MISS_THRESH = 8
) (
  input  upd_kind_e         kind_i,
  input  logic [CONF_W-1:0] conf_i,
  input  logic [MISS_W-1:0] miss_i,
  output logic              wr_en_o,
  output logic [CONF_W-1:0] conf_o,
  output logic [MISS_W-1:0] miss_o,
  output logic              promote_o
);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [MISS_W-1:0] MISS_MAX = '1;
  localparam logic [31:0]       THR      = MISS_THRESH;

  logic [MISS_W-1:0] miss_up;
  logic [MISS_W-1:0] miss_dn;
  logic [CONF_W-1:0] conf_up;
  logic              over;

  assign miss_up = (miss_i == MISS_MAX) ? MISS_MAX : miss_i + 1'b1;
  assign miss_dn = (miss_i == '0) ? '0 : miss_i - 1'b1;
  assign conf_up = (conf_i == CONF_MAX) ? CONF_MAX : conf_i + 1'b1;
  assign over    = {{(32-MISS_W){1'b0}}, miss_up} > THR;

  always_comb begin
    wr_en_o   = 1'b0;
    conf_o    = conf_i;
    miss_o    = miss_i;
    promote_o = 1'b0;
    unique case (kind_i)
      UPD_ALLOC: begin
        wr_en_o = 1'b1;
        conf_o  = '0;
        miss_o  = '0;
      end
      UPD_HIT_OK: begin
        wr_en_o = 1'b1;
        conf_o  = conf_up;
        miss_o  = miss_dn;
      end
      UPD_HIT_BAD: begin
        wr_en_o   = 1'b1;
        conf_o    = '0;
        promote_o = over;
        miss_o    = over ? '0 : miss_up;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/last_value_predictor.sv
module last_value_predictor
  import lvp_pkg::*;
#(
  parameter int WADDR_W      = 30,
  parameter int IDX_W        = 6,
  parameter int DATA_W       = 32,
  parameter int CONF_W       = 2,
  parameter int CONF_USE_MIN = 2,
  parameter int MISS_W       = 4,
  parameter int MISS_THRESH  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_valid_i,
  input  logic [WADDR_W-1:0] lookup_addr_i,
  output logic               pred_valid_o,
  output logic               pred_hit_o,
  output logic               pred_use_o,
  output logic [DATA_W-1:0]  pred_value_o,
  input  logic               commit_valid_i,
  input  logic [WADDR_W-1:0] commit_addr_i,
  input  logic [DATA_W-1:0]  commit_value_i,
  input  logic               commit_correct_i,
  output logic               promo_valid_o,
  output logic [WADDR_W-1:0] promo_addr_o
);
  localparam int TAG_W = WADDR_W - IDX_W;
  localparam logic [CONF_W-1:0] USE_MIN = CONF_W'(CONF_USE_MIN);

  logic [IDX_W-1:0]  lk_idx, cm_idx;
  logic [TAG_W-1:0]  lk_tag, cm_tag;
  logic              lk_valid, cm_valid;
  logic [TAG_W-1:0]  lk_tag_rd, cm_tag_rd;
  logic [DATA_W-1:0] lk_data;
  logic [CONF_W-1:0] lk_conf, cm_conf;
  logic [MISS_W-1:0] cm_miss;
  logic              lk_hit, cm_hit;

  upd_kind_e         kind;
  logic              wr_en, promote;
  logic [CONF_W-1:0] conf_nxt;
  logic [MISS_W-1:0] miss_nxt;

  assign lk_idx = lookup_addr_i[IDX_W-1:0];
  assign lk_tag = lookup_addr_i[WADDR_W-1:IDX_W];
  assign cm_idx = commit_addr_i[IDX_W-1:0];
  assign cm_tag = commit_addr_i[WADDR_W-1:IDX_W];

  lvp_table #(
    .IDX_W (IDX_W), .TAG_W (TAG_W), .DATA_W (DATA_W),
    .CONF_W(CONF_W), .MISS_W(MISS_W)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_idx_i  (lk_idx),
    .lk_valid_o(lk_valid),
    .lk_tag_o  (lk_tag_rd),
    .lk_data_o (lk_data),
    .lk_conf_o (lk_conf),
    .cm_idx_i  (cm_idx),
    .cm_valid_o(cm_valid),
    .cm_tag_o  (cm_tag_rd),
    .cm_conf_o (cm_conf),
    .cm_miss_o (cm_miss),
    .wr_en_i   (wr_en),
    .wr_tag_i  (cm_tag),
    .wr_data_i (commit_value_i),
    .wr_conf_i (conf_nxt),
    .wr_miss_i (miss_nxt)
  );

  assign lk_hit = lk_valid && (lk_tag_rd == lk_tag);
  assign cm_hit = cm_valid && (cm_tag_rd == cm_tag);

  always_comb begin
    if (!commit_valid_i)       kind = UPD_NONE;
    else if (!cm_hit)          kind = UPD_ALLOC;
    else if (commit_correct_i) kind = UPD_HIT_OK;
    else                       kind = UPD_HIT_BAD;
  end

  lvp_update #(
    .CONF_W(CONF_W), .MISS_W(MISS_W), .MISS_THRESH(MISS_THRESH)
  ) u_update (
    .kind_i   (kind),
    .conf_i   (cm_conf),
    .miss_i   (cm_miss),
    .wr_en_o  (wr_en),
    .conf_o   (conf_nxt),
    .miss_o   (miss_nxt),
    .promote_o(promote)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o  <= 1'b0;
      pred_hit_o    <= 1'b0;
      pred_use_o    <= 1'b0;
      pred_value_o  <= '0;
      promo_valid_o <= 1'b0;
      promo_addr_o  <= '0;
    end else begin
      pred_valid_o  <= lookup_valid_i;
      pred_hit_o    <= lookup_valid_i && lk_hit;
      pred_use_o    <= lookup_valid_i && lk_hit && (lk_conf >= USE_MIN);
      pred_value_o  <= (lookup_valid_i && lk_hit) ? lk_data : '0;
      promo_valid_o <= promote;
      promo_addr_o  <= promote ? commit_addr_i : '0;
    end
  end

  AST_PRED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> pred_valid_o); // R2
  AST_PRED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !pred_valid_o); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_hit_o |-> pred_valid_o); // R2
  AST_USE_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_use_o |-> pred_hit_o); // R6
  AST_PROMO_AFTER_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promo_valid_o |-> $past(commit_valid_i && !commit_correct_i)); // R8
  AST_PROMO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promo_valid_o |-> promo_addr_o == $past(commit_addr_i)); // R8
endmodule

// File: tb/tb_last_value_predictor.sv
`timescale 1ns/1ps
module tb_last_value_predictor;
  localparam int WADDR_W = 30;
  localparam int DATA_W  = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               lookup_valid = 1'b0;
  logic [WADDR_W-1:0] lookup_addr = '0;
  logic               pred_valid, pred_hit, pred_use;
  logic [DATA_W-1:0]  pred_value;
  logic               commit_valid = 1'b0;
  logic [WADDR_W-1:0] commit_addr = '0;
  logic [DATA_W-1:0]  commit_value = '0;
  logic               commit_correct = 1'b0;
  logic               promo_valid;
  logic [WADDR_W-1:0] promo_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  last_value_predictor dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lookup_valid), .lookup_addr_i(lookup_addr),
    .pred_valid_o(pred_valid), .pred_hit_o(pred_hit),
    .pred_use_o(pred_use), .pred_value_o(pred_value),
    .commit_valid_i(commit_valid), .commit_addr_i(commit_addr),
    .commit_value_i(commit_value), .commit_correct_i(commit_correct),
    .promo_valid_o(promo_valid), .promo_addr_o(promo_addr)
  );

  localparam logic [WADDR_W-1:0] ADDR_A = 30'h100;
  localparam logic [WADDR_W-1:0] ADDR_B = 30'h140; // same index as A, other tag
  localparam logic [WADDR_W-1:0] ADDR_C = 30'h123;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [WADDR_W-1:0] a, input bit e_hit,
                           input bit e_use, input logic [DATA_W-1:0] e_val,
                           input string req);
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = a;
    @(negedge clk);
    lookup_valid = 1'b0;
    chk(pred_valid == 1'b1, req, "pred_valid", 32'(pred_valid), 32'd1);
    chk(pred_hit == e_hit, req, "pred_hit", 32'(pred_hit), 32'(e_hit));
    chk(pred_use == e_use, req, "pred_use", 32'(pred_use), 32'(e_use));
    chk(pred_value == e_val, req, "pred_value", pred_value, e_val);
  endtask

  task automatic do_commit(input logic [WADDR_W-1:0] a, input logic [DATA_W-1:0] v,
                           input bit ok, input bit e_promo, input string req);
    @(negedge clk);
    commit_valid = 1'b1; commit_addr = a; commit_value = v; commit_correct = ok;
    @(negedge clk);
    commit_valid = 1'b0;
    chk(promo_valid == e_promo, req, "promo_valid", 32'(promo_valid), 32'(e_promo));
    if (e_promo)
      chk(promo_addr == a, req, "promo_addr", 32'(promo_addr), 32'(a));
  endtask

  task automatic t_reset();
    chk(pred_valid == 1'b0 && promo_valid == 1'b0, "R1", "outputs after reset",
        {30'd0, pred_valid, promo_valid}, 32'd0);
    do_lookup(ADDR_A, 1'b0, 1'b0, '0, "R1");
  endtask

  task automatic t_alloc_hit();
    do_commit(ADDR_A, 32'h1111_0000, 1'b1, 1'b0, "R4");
    do_lookup(ADDR_A, 1'b1, 1'b0, 32'h1111_0000, "R3");
    do_lookup(ADDR_B, 1'b0, 1'b0, '0, "R2");
  endtask

  task automatic t_confidence();
    do_commit(ADDR_A, 32'h1111_0001, 1'b1, 1'b0, "R5");
    do_lookup(ADDR_A, 1'b1, 1'b0, 32'h1111_0001, "R6"); // conf 1
    do_commit(ADDR_A, 32'h1111_0002, 1'b1, 1'b0, "R5");
    do_lookup(ADDR_A, 1'b1, 1'b1, 32'h1111_0002, "R6"); // conf 2
    do_commit(ADDR_A, 32'h1111_0003, 1'b1, 1'b0, "R5");
    do_commit(ADDR_A, 32'h1111_0004, 1'b1, 1'b0, "R5");
    do_lookup(ADDR_A, 1'b1, 1'b1, 32'h1111_0004, "R5"); // conf 3 saturated
    do_commit(ADDR_A, 32'h2222_0000, 1'b0, 1'b0, "R5");
    do_lookup(ADDR_A, 1'b1, 1'b0, 32'h2222_0000, "R5"); // cleared
    do_commit(ADDR_A, 32'h2222_0001, 1'b1, 1'b0, "R5");
    do_lookup(ADDR_A, 1'b1, 1'b0, 32'h2222_0001, "R5"); // 1, not 3
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = ADDR_A;
    commit_valid = 1'b1; commit_addr = ADDR_A;
    commit_value = 32'h3333_0000; commit_correct = 1'b1;
    @(negedge clk);
    lookup_valid = 1'b0; commit_valid = 1'b0;
    chk(pred_value == 32'h2222_0001, "R9", "old value on collision",
        pred_value, 32'h2222_0001);
    do_lookup(ADDR_A, 1'b1, 1'b1, 32'h3333_0000, "R9"); // conf 2 now
  endtask

  task automatic t_replace();
    do_commit(ADDR_B, 32'h4444_0000, 1'b1, 1'b0, "R4");
    do_lookup(ADDR_A, 1'b0, 1'b0, '0, "R4");
    do_lookup(ADDR_B, 1'b1, 1'b0, 32'h4444_0000, "R4");
  endtask

  task automatic t_promotion();
    do_commit(ADDR_C, 32'd598, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) do_commit(ADDR_C, 32'd598, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 8; i++) do_commit(ADDR_C, 32'(600 + i), 1'b0, 1'b0, "R7");
    do_commit(ADDR_C, 32'd700, 1'b0, 1'b1, "R8");
    @(negedge clk);
    chk(promo_valid == 1'b0, "R8", "single-cycle pulse", 32'(promo_valid), 32'd0);
    for (int i = 0; i < 8; i++) do_commit(ADDR_C, 32'(800 + i), 1'b0, 1'b0, "R8");
    do_commit(ADDR_C, 32'd900, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_updown();
    for (int i = 0; i < 5; i++) do_commit(ADDR_C, 32'(i), 1'b0, 1'b0, "R7");
    for (int i = 0; i < 2; i++) do_commit(ADDR_C, 32'(i), 1'b1, 1'b0, "R7");
    for (int i = 0; i < 5; i++) do_commit(ADDR_C, 32'(i), 1'b0, 1'b0, "R7");
    do_commit(ADDR_C, 32'd99, 1'b0, 1'b1, "R7");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_hit();
    t_confidence();
    t_same_cycle();
    t_replace();
    t_promotion();
    t_updown();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule